// File: doc/BRIEF.md
# Oscillator-Pair Calibration Controller

This block tunes a pair of configurable ring oscillators that feed a coherent-sampling random bit source. A digitiser measures the beat period between the two oscillators and hands over one count per measurement, marked by a one-cycle request strobe. The controller checks each count against a fixed acceptance band. The lower bound is inclusive and the upper bound is exclusive. The controller groups the strobed samples into windows of 128.

A window in which no count lands inside the band shows that the current oscillator pairing gives too short or too long a beat period. The controller then moves the oscillator select word on to the next configuration in plain increasing order. The select word carries two bits per configurable stage and wraps to zero after its largest value, so the search never stops. A status flag reports that a usable configuration has been seen. It rises on any in-band sample and drops when the controller reconfigures. The controller starts searching out of reset and keeps checking for as long as it runs.

Top module: `oscPairCalibrator`

## Requirements
- R1: After reset, the select word, the matched flag and the internal window and good-sample counts are all zero.
- R2: Cycles with the request strobe low change neither the outputs nor the window position, whatever the count input carries.
- R3: A strobed count is in band when LOW_BOUND <= count < HIGH_BOUND. An in-band sample sets matched to 1 in the cycle after the strobe.
- R4: On the 128th strobed sample of a window, if no sample of that window was in band, the select word increases by one and matched goes to 0. Both changes are visible in the cycle after that strobe.
- R5: The record of good samples is cleared at every window end, so a good sample in one window does not stop the next window from advancing.
- R6: An in-band sample in the last slot of a window is counted before the window decision, so it prevents the advance and sets matched.
- R7: A window in which all 128 samples are in band does not advance the select word.
- R8: The select word wraps from all ones to zero on an advance.
- R9: Once set, matched stays 1 across window ends until the next reconfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleReq | input | 1 | One-cycle strobe: beatCount holds a new sample |
| beatCount | input | COUNT_W | Beat period measured by the digitiser |
| oscSel | output | 2*STAGES | Oscillator configuration select word |
| matched | output | 1 | High once an in-band sample has been seen since the last reconfiguration |

## Verification
The bench builds the block with STAGES=2, COUNT_W=8, LOW_BOUND=59 and HIGH_BOUND=100. The select word is then four bits wide. Sixteen windows with no good sample, about two thousand strobes, are enough to see it wrap to zero. The narrow count lets random stimulus land right on both band edges, 58, 59, 99 and 100. Directed windows cover these cases:
- a lone good sample in the last slot;
- a window that is fully in band, which would overflow a seven-bit good count;
- idle cycles spread through a window.

// File: rtl/oscCalPkg.sv
`timescale 1ns/1ps
package oscCalPkg;
  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic take;      // a sample is processed this cycle
    logic closeWin;  // this sample is the last of its window
    logic advance;   // move to the next oscillator configuration
  } calStrobe_t;
endpackage

// File: rtl/oscCalDatapath.sv
`timescale 1ns/1ps
module oscCalDatapath
  import oscCalPkg::*;
#(
  parameter int COUNT_W    = 16,
  parameter int SEL_W      = 8,
  parameter int WIN_W      = 7,
  parameter int LOW_BOUND  = 59,
  parameter int HIGH_BOUND = 160
) (
  input  logic               clk,
  input  logic               rstN,
  input  calStrobe_t         strobe,
  input  logic [COUNT_W-1:0] beatCount,
  output logic               inRange,
  output logic               lastSlot,
  output logic               winHasGood,
  output logic [SEL_W-1:0]   selWord
);
  // one spare bit so HIGH_BOUND may equal 2**COUNT_W
  localparam int CMP_W = COUNT_W + 1;
  localparam logic [CMP_W-1:0] LO_V = CMP_W'(LOW_BOUND);
  localparam logic [CMP_W-1:0] HI_V = CMP_W'(HIGH_BOUND);

  logic [WIN_W-1:0] sampleCnt;
  logic [WIN_W-1:0] goodCnt;
  logic [CMP_W-1:0] countExt;

  assign countExt   = {1'b0, beatCount};
  assign inRange    = (countExt >= LO_V) && (countExt < HI_V);
  assign lastSlot   = (sampleCnt == {WIN_W{1'b1}});
  // presence test instead of count+1: cannot wrap on a fully good window
  assign winHasGood = (goodCnt != '0) || inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      goodCnt   <= '0;
      selWord   <= '0;
    end else begin
      if (strobe.take) begin
        sampleCnt <= sampleCnt + 1'b1;
        if (strobe.closeWin)
          goodCnt <= '0;
        else if (inRange)
          goodCnt <= goodCnt + 1'b1;
      end
      if (strobe.advance)
        selWord <= selWord + 1'b1;
    end
  end

  // R2: no strobe, no movement
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> ($stable(sampleCnt) && $stable(goodCnt) && $stable(selWord)));

  // R8: an advance is a plain modular increment
  p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (selWord == SEL_W'($past(selWord) + 1'b1)));

  // R6: an in-band sample never changes the configuration
  p_good_keeps_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && inRange) |=> $stable(selWord));

  // R7: good count never runs ahead of the slot index, so it cannot overflow
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    goodCnt <= sampleCnt);

  // R5: the window end clears the good record
  p_window_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.closeWin |=> (goodCnt == '0));
endmodule

// File: rtl/oscCalControl.sv
`timescale 1ns/1ps
module oscCalControl
  import oscCalPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleReq,
  input  logic       inRange,
  input  logic       lastSlot,
  input  logic       winHasGood,
  output calStrobe_t strobe,
  output logic       matched
);
  always_comb begin
    strobe.take     = sampleReq;
    strobe.closeWin = sampleReq && lastSlot;
    strobe.advance  = sampleReq && lastSlot && !winHasGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      matched <= 1'b0;
    else if (strobe.advance)
      matched <= 1'b0;
    else if (sampleReq && inRange)
      matched <= 1'b1;
  end

  // R3: an in-band sample raises matched next cycle
  p_good_sets_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq && inRange) |=> matched);

  // R4: a reconfiguration clears matched
  p_advance_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> !matched);

  // R9: matched falls only through an advance
  p_match_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (matched && !strobe.advance) |=> matched);

  // R4: an advance only ever happens on a strobed last slot
  p_advance_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> (strobe.take && strobe.closeWin));
endmodule

// File: rtl/oscPairCalibrator.sv
`timescale 1ns/1ps
module oscPairCalibrator
  import oscCalPkg::*;
#(
  parameter int COUNT_W    = 16,
  parameter int STAGES     = 4,
  parameter int WIN_W      = 7,
  parameter int LOW_BOUND  = 59,
  parameter int HIGH_BOUND = 160
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleReq,
  input  logic [COUNT_W-1:0]    beatCount,
  output logic [2*STAGES-1:0]   oscSel,
  output logic                  matched
);
  localparam int SEL_W = 2 * STAGES;

  calStrobe_t strobe;
  logic       inRange;
  logic       lastSlot;
  logic       winHasGood;

  oscCalDatapath #(
    .COUNT_W   (COUNT_W),
    .SEL_W     (SEL_W),
    .WIN_W     (WIN_W),
    .LOW_BOUND (LOW_BOUND),
    .HIGH_BOUND(HIGH_BOUND)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .beatCount (beatCount),
    .inRange   (inRange),
    .lastSlot  (lastSlot),
    .winHasGood(winHasGood),
    .selWord   (oscSel)
  );

  oscCalControl uControl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleReq (sampleReq),
    .inRange   (inRange),
    .lastSlot  (lastSlot),
    .winHasGood(winHasGood),
    .strobe    (strobe),
    .matched   (matched)
  );
endmodule

// File: tb/oscPairCalibrator_test.sv
`timescale 1ns/1ps
module oscPairCalibrator_test;
  localparam int CW = 8;
  localparam int ST = 2;
  localparam int SW = 2 * ST;
  localparam int LO = 59;
  localparam int HI = 100;
  localparam int WIN = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleReq = 1'b0;
  logic [CW-1:0] beatCount = '0;
  logic [SW-1:0] oscSel;
  logic          matched;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference state
  int mSlot = 0;
  int mGood = 0;
  int mSel  = 0;
  bit mMatch = 0;

  always #4 clk = ~clk;  // 125 MHz

  oscPairCalibrator #(
    .COUNT_W(CW), .STAGES(ST), .WIN_W(7), .LOW_BOUND(LO), .HIGH_BOUND(HI)
  ) uut (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .beatCount(beatCount),
    .oscSel(oscSel), .matched(matched)
  );

  function automatic bit inBand(input int c);
    return (c >= LO) && (c < HI);
  endfunction

  function automatic int goodVal();
    return int'($urandom_range(LO, HI - 1));
  endfunction

  function automatic int badVal();
    if ($urandom_range(0, 1) == 0) return int'($urandom_range(0, LO - 1));
    return int'($urandom_range(HI, (1 << CW) - 1));
  endfunction

  task automatic check(input string req, input int gotSel, input int expSel,
                       input bit gotM, input bit expM);
    nChecks++;
    if (gotSel != expSel || gotM != expM) begin
      nFails++;
      $display("FAIL %s: sel=%0d match=%0b expected sel=%0d match=%0b",
               req, gotSel, gotM, expSel, expM);
    end
  endtask

  // drive one cycle, update the model, compare at the next falling edge
  task automatic step(input bit req, input int c, input string tag);
    sampleReq = req;
    beatCount = CW'(c);
    @(posedge clk);
    if (req) begin
      bit g = inBand(c);
      bit hasGood = (mGood != 0) || g;
      if (mSlot == WIN - 1) begin
        if (!hasGood) begin
          mSel = (mSel + 1) % (1 << SW);
          mMatch = 0;
        end else if (g) mMatch = 1;
        mGood = 0;
      end else begin
        if (g) begin mGood++; mMatch = 1; end
      end
      mSlot = (mSlot + 1) % WIN;
    end
    @(negedge clk);
    check(tag, int'(oscSel), mSel, matched, mMatch);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", int'(oscSel), 0, matched, 1'b0);

    // R2: idle cycles with in-band values are ignored
    for (int i = 0; i < 10; i++) step(1'b0, 70, "R2");

    // R4 with idle gaps (R2): an all-bad window advances on its 128th strobe
    for (int i = 0; i < WIN; i++) begin
      if (i % 9 == 0) step(1'b0, 80, "R2");
      step(1'b1, badVal(), "R4");
    end
    check("R4", int'(oscSel), 1, matched, 1'b0);

    // R3 lower edge: only 59 is good
    for (int i = 0; i < WIN; i++) step(1'b1, (i == 5) ? 59 : 58, "R3");
    check("R3", int'(oscSel), 1, matched, 1'b1);

    // R4 edges 58 and 100 both bad
    for (int i = 0; i < WIN; i++) step(1'b1, (i % 2) ? 100 : 58, "R4");
    check("R4", int'(oscSel), 2, matched, 1'b0);

    // R3 upper edge: 99 is good
    for (int i = 0; i < WIN; i++) step(1'b1, (i == 64) ? 99 : 100, "R3");
    check("R3", int'(oscSel), 2, matched, 1'b1);

    // R5: good in slot 0 only, then a fully bad window advances
    for (int i = 0; i < WIN; i++) step(1'b1, (i == 0) ? goodVal() : badVal(), "R9");
    check("R9", int'(oscSel), 2, matched, 1'b1);
    for (int i = 0; i < WIN; i++) step(1'b1, badVal(), "R5");
    check("R5", int'(oscSel), 3, matched, 1'b0);

    // R6: only the last sample is good
    for (int i = 0; i < WIN; i++) step(1'b1, (i == WIN - 1) ? goodVal() : badVal(), "R6");
    check("R6", int'(oscSel), 3, matched, 1'b1);

    // R7: every sample good
    for (int i = 0; i < WIN; i++) step(1'b1, goodVal(), "R7");
    check("R7", int'(oscSel), 3, matched, 1'b1);
    for (int i = 0; i < WIN; i++) step(1'b1, badVal(), "R4");
    check("R4", int'(oscSel), 4, matched, 1'b0);

    // R8: run the select word through its wrap
    for (int w = 0; w < 12; w++)
      for (int i = 0; i < WIN; i++) step(1'b1, badVal(), "R8");
    check("R8", int'(oscSel), 0, matched, 1'b0);

    // random mix: sparse good samples, random idle cycles
    for (int w = 0; w < 24; w++)
      for (int i = 0; i < WIN; i++) begin
        bit rq = ($urandom_range(0, 3) != 0);
        int c = ($urandom_range(0, 150) == 0) ? goodVal() : badVal();
        step(rq, c, "R4");
      end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule